// File: doc/BRIEF.md
# Single-Spare Column Reconfiguration Controller

This block governs one column of a processor-cell lattice. The column has `NCELL` working positions and one extra physical cell that serves as the spare, so it has `NCELL+1` physical cells in total. A small register, the column state word, holds a valid flag and the index of the physical cell that has been declared faulty. The per-cell link masks and the logical-to-physical shift selects are derived from that word without any clock delay. When a fault sits at physical index `f`, every logical cell at or above `f` moves up by one physical position. The faulty cell's links are voided and the spare's links become active.

Execution proceeds in steps. Each accepted step writes a step identifier and the column state word then in force into a two-entry log. When a fault is reported, a short sequence runs. The block isolates the reported index for one cycle and commits the new state word. It then requests a retry from the step logged before the latest one, and holds that request until it is acknowledged. A second fault in a column whose spare is already used is lethal. A lethal fault raises a sticky failure flag and does not request a retry. Reports that arrive while a reconfiguration is in progress wait in a one-entry queue. Reports with an index outside the column are dropped and flagged.

Top module: `spare_shift_col`

## Requirements
- R1: After reset the column state word is zero, only the spare (physical `NCELL`) has its links voided, no shift select is set, and `retry_req`, `col_failed` and `bad_idx` are low.
- R2: `phys_void` bit p is set when physical cell p has void links. With no fault only bit `NCELL` is set. With a fault at index f only bit f is set. Exactly one bit is set at all times.
- R3: `shift_sel` bit k is set when logical cell k is served by physical cell k+1. This holds exactly when a fault is recorded and k is greater than or equal to the failed index.
- R4: The column state word is `{valid, index}`, with the valid flag as the MSB. A report of an in-range index f in the idle state changes it to `{1, f}` on the second rising edge after the report, and leaves it unchanged at the first edge.
- R5: The isolate state lasts exactly one cycle. `retry_req` rises on the same edge that commits the state word, stays high until `retry_ack` is sampled, and falls on the edge that samples `retry_ack`.
- R6: A `step_valid` pulse in the idle state logs `{step_id, state word}`. The earlier entry becomes the rollback point. `retry_step` shows the rollback identifier and `rollback_csw` shows the state word logged with it.
- R7: A `step_valid` pulse while a reconfiguration is in progress is ignored, so the rollback point does not change.
- R8: A fault report when the spare is already in use sets `col_failed` two edges later. The flag stays set until reset, the state word is unchanged, and no retry is requested.
- R9: One valid report that arrives during isolate or retry is queued and processed after the acknowledgement, as if it had just been reported.
- R10: A report whose index exceeds `NCELL` is ignored and raises `bad_idx` for the one cycle after the report edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault report strobe |
| fault_idx | input | IDXW | Physical index of the reported faulty cell |
| step_valid | input | 1 | Log a new execution step |
| step_id | input | STEPW | Identifier of the step being logged |
| retry_ack | input | 1 | Acknowledges the retry request |
| phys_void | output | NCELL+1 | Per-physical-cell link mask, 1 = void |
| shift_sel | output | NCELL | Per-logical-cell shift select, 1 = uses physical k+1 |
| csw | output | IDXW+1 | Column state word `{valid, index}` |
| retry_req | output | 1 | Retry request |
| retry_step | output | STEPW | Step identifier at the rollback point |
| rollback_csw | output | IDXW+1 | State word logged with the rollback point |
| col_failed | output | 1 | Sticky lethal-fault flag |
| bad_idx | output | 1 | Out-of-range report flag |

## Verification
Inputs are driven after a falling edge and outputs are sampled at the next falling edge, so each check sees a whole number of rising edges. The masks and shift selects follow the state word without delay. The state word itself appears two edges after a report, and the bench checks it at both the first and the second edge. `retry_req` is checked two edges after a report, again after a cycle with no acknowledgement, and one edge after the acknowledgement. A lethal outcome is checked two edges after the report. `bad_idx` and step logging are checked one edge after their stimulus. Every in-range fault index is swept, each followed by a lethal second fault, and every out-of-range index is swept as well.

// File: rtl/spsh_pkg.sv
package spsh_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISOLATE, ST_RETRY} seq_state_e;

  // physical cell p has void links: the failed one, or the spare when no fault
  function automatic logic phys_is_void(int p, logic vld, int fidx, int spare);
    return vld ? (p == fidx) : (p == spare);
  endfunction

  // logical cell k moves up one physical slot when at or above the failed index
  function automatic logic logical_shifted(int k, logic vld, int fidx);
    return vld && (k >= fidx);
  endfunction
endpackage

// File: rtl/spsh_linkmap.sv
module spsh_linkmap #(
  parameter int NCELL = 4,
  parameter int IDXW  = $clog2(NCELL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csw_valid,
  input  logic [IDXW-1:0]  csw_idx,
  output logic [NCELL:0]   phys_void,
  output logic [NCELL-1:0] shift_sel
);
  import spsh_pkg::*;

  for (genvar p = 0; p <= NCELL; p++) begin : g_void
    assign phys_void[p] = phys_is_void(p, csw_valid, int'(csw_idx), NCELL);
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_shift
    assign shift_sel[k] = logical_shifted(k, csw_valid, int'(csw_idx));
  end

  assert_single_void_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phys_void) == 1);

  assert_spare_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_void[NCELL] |-> (shift_sel == '0));
endmodule

// File: rtl/spsh_steplog.sv
module spsh_steplog #(
  parameter int STEPW = 8,
  parameter int CSWW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             log_en,
  input  logic [STEPW-1:0] step_id,
  input  logic [CSWW-1:0]  csw_now,
  output logic [STEPW-1:0] prev_id,
  output logic [CSWW-1:0]  prev_csw
);
  logic [STEPW-1:0] cur_id;
  logic [CSWW-1:0]  cur_csw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_id   <= '0;
      cur_csw  <= '0;
      prev_id  <= '0;
      prev_csw <= '0;
    end else if (log_en) begin
      prev_id  <= cur_id;
      prev_csw <= cur_csw;
      cur_id   <= step_id;
      cur_csw  <= csw_now;
    end
  end

  assert_rollback_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    log_en |=> (prev_id == $past(cur_id)) && (prev_csw == $past(cur_csw)));

  assert_log_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !log_en |=> $stable(prev_id) && $stable(cur_id));
endmodule

// File: rtl/spsh_seq.sv
module spsh_seq #(
  parameter int NCELL = 4,
  parameter int IDXW  = $clog2(NCELL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_valid,
  input  logic [IDXW-1:0] fault_idx,
  input  logic            step_valid,
  input  logic            retry_ack,
  output logic            csw_valid,
  output logic [IDXW-1:0] csw_idx,
  output logic            log_en,
  output logic            retry_req,
  output logic            col_failed,
  output logic            bad_idx
);
  import spsh_pkg::*;

  seq_state_e      state_q;
  logic [IDXW-1:0] pend_idx;
  logic            q_valid;
  logic [IDXW-1:0] q_idx;

  // named internal events
  logic fault_ok, fault_bad, take_queued, take_live, commit_evt, lethal_evt, busy;
  assign fault_ok    = fault_valid && (int'(fault_idx) <= NCELL);
  assign fault_bad   = fault_valid && !fault_ok;
  assign take_queued = (state_q == ST_IDLE) && q_valid;
  assign take_live   = (state_q == ST_IDLE) && !q_valid && fault_ok;
  assign commit_evt  = (state_q == ST_ISOLATE) && !csw_valid;
  assign lethal_evt  = (state_q == ST_ISOLATE) && csw_valid;
  assign busy        = (state_q != ST_IDLE);

  assign log_en    = (state_q == ST_IDLE) && step_valid;
  assign retry_req = (state_q == ST_RETRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_idx   <= '0;
      q_valid    <= 1'b0;
      q_idx      <= '0;
      csw_valid  <= 1'b0;
      csw_idx    <= '0;
      col_failed <= 1'b0;
      bad_idx    <= 1'b0;
    end else begin
      bad_idx <= fault_bad;
      if (take_queued) begin
        pend_idx <= q_idx;
        state_q  <= ST_ISOLATE;
        q_valid  <= fault_ok;
        q_idx    <= fault_idx;
      end else if (take_live) begin
        pend_idx <= fault_idx;
        state_q  <= ST_ISOLATE;
      end
      if (busy && fault_ok && !q_valid) begin
        q_valid <= 1'b1;
        q_idx   <= fault_idx;
      end
      if (commit_evt) begin
        csw_valid <= 1'b1;
        csw_idx   <= pend_idx;
        state_q   <= ST_RETRY;
      end
      if (lethal_evt) begin
        col_failed <= 1'b1;
        state_q    <= ST_IDLE;
      end
      if ((state_q == ST_RETRY) && retry_ack) state_q <= ST_IDLE;
    end
  end

  assert_isolate_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISOLATE) |=> (state_q != ST_ISOLATE));

  assert_retry_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req && !retry_ack) |=> retry_req);

  assert_retry_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req && retry_ack) |=> !retry_req);

  assert_csw_only_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ISOLATE) |=> $stable(csw_valid) && $stable(csw_idx));

  assert_failed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_failed |=> col_failed);

  assert_lethal_no_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lethal_evt |=> !retry_req && $stable(csw_idx));

  assert_bad_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bad |=> bad_idx);
endmodule

// File: rtl/spare_shift_col.sv
module spare_shift_col #(
  parameter int NCELL = 4,
  parameter int STEPW = 8,
  parameter int IDXW  = $clog2(NCELL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_valid,
  input  logic [IDXW-1:0]  fault_idx,
  input  logic             step_valid,
  input  logic [STEPW-1:0] step_id,
  input  logic             retry_ack,
  output logic [NCELL:0]   phys_void,
  output logic [NCELL-1:0] shift_sel,
  output logic [IDXW:0]    csw,
  output logic             retry_req,
  output logic [STEPW-1:0] retry_step,
  output logic [IDXW:0]    rollback_csw,
  output logic             col_failed,
  output logic             bad_idx
);
  localparam int CSWW = IDXW + 1;

  logic            csw_valid;
  logic [IDXW-1:0] csw_idx;
  logic            log_en;

  assign csw = {csw_valid, csw_idx};

  spsh_seq #(.NCELL(NCELL), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .fault_valid(fault_valid), .fault_idx(fault_idx),
    .step_valid(step_valid), .retry_ack(retry_ack),
    .csw_valid(csw_valid), .csw_idx(csw_idx),
    .log_en(log_en), .retry_req(retry_req),
    .col_failed(col_failed), .bad_idx(bad_idx)
  );

  spsh_linkmap #(.NCELL(NCELL), .IDXW(IDXW)) u_map (
    .clk(clk), .rst_n(rst_n),
    .csw_valid(csw_valid), .csw_idx(csw_idx),
    .phys_void(phys_void), .shift_sel(shift_sel)
  );

  spsh_steplog #(.STEPW(STEPW), .CSWW(CSWW)) u_log (
    .clk(clk), .rst_n(rst_n),
    .log_en(log_en), .step_id(step_id), .csw_now(csw),
    .prev_id(retry_step), .prev_csw(rollback_csw)
  );
endmodule

// File: tb/test_spare_shift_col.sv
module test_spare_shift_col;
  localparam int NCELL = 4;
  localparam int STEPW = 8;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_valid = 1'b0;
  logic [IDXW-1:0] fault_idx = '0;
  logic step_valid = 1'b0;
  logic [STEPW-1:0] step_id = '0;
  logic retry_ack = 1'b0;
  logic [NCELL:0] phys_void;
  logic [NCELL-1:0] shift_sel;
  logic [IDXW:0] csw;
  logic retry_req;
  logic [STEPW-1:0] retry_step;
  logic [IDXW:0] rollback_csw;
  logic col_failed;
  logic bad_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spare_shift_col #(.NCELL(NCELL), .STEPW(STEPW), .IDXW(IDXW)) i_spare_shift_col (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_idx(fault_idx),
    .step_valid(step_valid), .step_id(step_id), .retry_ack(retry_ack),
    .phys_void(phys_void), .shift_sel(shift_sel), .csw(csw),
    .retry_req(retry_req), .retry_step(retry_step), .rollback_csw(rollback_csw),
    .col_failed(col_failed), .bad_idx(bad_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fault_valid = 1'b0; step_valid = 1'b0; retry_ack = 1'b0;
    edge1(); edge1();
    rst_n = 1'b1;
  endtask

  task automatic log_step(input int id);
    step_valid = 1'b1; step_id = STEPW'(id);
    edge1();
    step_valid = 1'b0;
  endtask

  function automatic int exp_void(input bit vld, input int f);
    return vld ? (1 << f) : (1 << NCELL);
  endfunction

  function automatic int exp_shift(input bit vld, input int f);
    if (!vld || f >= NCELL) return 0;
    return ((1 << NCELL) - 1) - ((1 << f) - 1);
  endfunction

  function automatic int exp_csw(input int f);
    return (1 << IDXW) | f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    edge1();
    chk("R1", "csw", int'(csw), 0);
    chk("R1", "void", int'(phys_void), exp_void(0, 0));
    chk("R1", "shift", int'(shift_sel), 0);
    chk("R1", "retry_req", int'(retry_req), 0);
    chk("R1", "col_failed", int'(col_failed), 0);
    chk("R1", "bad_idx", int'(bad_idx), 0);

    // sweep every in-range fault index, then a lethal second fault
    for (int f = 0; f <= NCELL; f++) begin
      do_reset();
      log_step(10 + f);
      log_step(20 + f);
      chk("R6", "retry_step after two logs", int'(retry_step), 10 + f);
      fault_valid = 1'b1; fault_idx = IDXW'(f);
      edge1();
      fault_valid = 1'b0;
      chk("R4", "csw first edge", int'(csw), 0);
      chk("R5", "retry_req first edge", int'(retry_req), 0);
      edge1();
      chk("R4", "csw committed", int'(csw), exp_csw(f));
      chk("R2", "void", int'(phys_void), exp_void(1, f));
      chk("R3", "shift", int'(shift_sel), exp_shift(1, f));
      chk("R5", "retry_req raised", int'(retry_req), 1);
      chk("R6", "retry_step", int'(retry_step), 10 + f);
      edge1();
      chk("R5", "retry_req held", int'(retry_req), 1);
      retry_ack = 1'b1;
      edge1();
      retry_ack = 1'b0;
      chk("R5", "retry_req dropped", int'(retry_req), 0);
      log_step(30 + f);
      log_step(40 + f);
      chk("R6", "retry_step new", int'(retry_step), 30 + f);
      chk("R6", "rollback_csw", int'(rollback_csw), exp_csw(f));
      fault_valid = 1'b1; fault_idx = IDXW'((f + 1) % (NCELL + 1));
      edge1();
      fault_valid = 1'b0;
      chk("R8", "col_failed early", int'(col_failed), 0);
      edge1();
      chk("R8", "col_failed", int'(col_failed), 1);
      chk("R8", "no retry", int'(retry_req), 0);
      chk("R8", "csw kept", int'(csw), exp_csw(f));
      edge1(); edge1();
      chk("R8", "col_failed sticky", int'(col_failed), 1);
    end

    // out-of-range indices
    do_reset();
    for (int b = NCELL + 1; b < (1 << IDXW); b++) begin
      fault_valid = 1'b1; fault_idx = IDXW'(b);
      edge1();
      fault_valid = 1'b0;
      chk("R10", "bad_idx", int'(bad_idx), 1);
      edge1();
      chk("R10", "bad_idx pulse", int'(bad_idx), 0);
      chk("R10", "no retry", int'(retry_req), 0);
      chk("R10", "csw unchanged", int'(csw), 0);
      chk("R10", "void unchanged", int'(phys_void), exp_void(0, 0));
    end

    // queued report and ignored step during reconfiguration
    do_reset();
    log_step(5);
    log_step(6);
    fault_valid = 1'b1; fault_idx = IDXW'(1);
    edge1();
    fault_idx = IDXW'(3);          // arrives during isolate: queued
    edge1();
    fault_valid = 1'b0;
    chk("R9", "first committed", int'(csw), exp_csw(1));
    step_valid = 1'b1; step_id = 8'd99;
    edge1();
    step_valid = 1'b0;
    chk("R7", "retry_step unchanged", int'(retry_step), 5);
    chk("R9", "col_failed before ack", int'(col_failed), 0);
    retry_ack = 1'b1;
    edge1();
    retry_ack = 1'b0;
    chk("R9", "retry_req dropped", int'(retry_req), 0);
    edge1();
    chk("R9", "queued still pending", int'(col_failed), 0);
    edge1();
    chk("R9", "queued lethal", int'(col_failed), 1);
    chk("R9", "csw kept", int'(csw), exp_csw(1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule